// File: doc/BRIEF.md
# Dual-FIFO Interprocessor Mailbox

This block passes 32-bit messages between a host CPU and a bank of numbered peripheral channels. The CPU sees a small register window. Channels hand their responses in through a per-channel available flag and data word. A lowest-number-first scanner moves those responses into an inbound FIFO, one word per cycle, for as long as that FIFO has room. The CPU then drains the FIFO through a read window. It can also look at the oldest word without removing it. A data-available interrupt is raised while the inbound FIFO holds anything and the interrupt is enabled.

In the other direction, the CPU writes a request into a write window. The low four bits of the written word select the target channel. An idle channel receives the word at once, in the same cycle. A channel that reports busy has the word parked in an outbound FIFO. The outbound FIFO only holds these parked requests; its level is visible to software. Overflow and underflow are recorded as sticky error flags, and any write to the configuration register clears them. Any access to an offset with no register reads zero and pulses an error strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both FIFOs are empty, both status registers read 0x4000_0000, the peek and configuration registers read 0xFFFF_FFFF and 0 respectively, and the interrupt is low.
- R2: A read at any aligned offset 0x80 to 0x8C returns the oldest inbound word and removes it, so words leave in the order they entered.
- R3: A read in the 0x80 to 0x8C window while the inbound FIFO is empty returns 0xFFFF_FFFF, removes nothing and sets the underflow flag (configuration bit 10).
- R4: A read at 0x90 returns the oldest inbound word without changing the fill level, or 0xFFFF_FFFF when the inbound FIFO is empty.
- R5: Status words put full in bit 31, empty in bit 30 and the fill level in bits 7:0. The inbound status is at 0x98 and the outbound status is at 0xB8.
- R6: In each cycle where the inbound FIFO is not full, the lowest-numbered channel with its available input high has its response pushed into the FIFO, and that channel's acknowledge pulses. No acknowledge is given while the FIFO is full.
- R7: A write in the 0xA0 to 0xAC window selects a channel with bits 3:0 of the value. If that channel is idle, its write-valid line alone pulses with the value on the write data port. If it is busy, the value goes into the outbound FIFO instead.
- R8: A request whose channel number is not below the channel count is neither delivered nor queued.
- R9: A request while the outbound FIFO is full is dropped and sets the overflow flag (configuration bit 9). This holds even when the target channel is idle.
- R10: In the configuration register at 0x9C, bit 0 is the data interrupt enable and bit 4 is the pending flag, equal to inbound-not-empty. The interrupt is high exactly when both are set. A write to 0x9C takes only bit 0 from the value and clears bits 8 to 10.
- R11: An access to an offset with no register in that direction (reads: 0x80–0x9C and 0xB8; writes: 0xA0–0xAC and 0x9C) reads zero, changes no state, and raises the error strobe in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busErr | output | 1 | Undefined-offset strobe |
| irqData | output | 1 | Data-available interrupt |
| chanAvail | input | CHAN_COUNT | Per-channel response ready |
| chanRespData | input | CHAN_COUNT*32 | Per-channel response words, channel 0 lowest |
| chanRespAck | output | CHAN_COUNT | Response taken this cycle |
| chanBusy | input | CHAN_COUNT | Per-channel busy |
| chanWrValid | output | CHAN_COUNT | Request delivered this cycle |
| chanWrData | output | 32 | Request word |

## Verification
The scanner is driven with a sparse set of ready channels in scrambled order. This shows whether the priority runs from the lowest number. It is also driven with every channel ready at once, which overfills the inbound FIFO. That shows whether scanning stops at full and resumes after one pop. Requests are sent to an idle channel, to a busy channel, to channel numbers beyond the count, and to an idle channel while the outbound FIFO is full. Together these separate direct delivery, queueing, rejection and the precedence of the full check. Reads through every alias of the pop window, the peek, and accesses in the wrong direction tell apart removal, non-removal and undefined decoding.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;

  typedef struct packed {
    logic inPush;
    logic inPop;
    logic outPush;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] FILL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= FILL;
    end else begin
      if (pop) begin
        slots[rdPtr] <= FILL;
        rdPtr <= nextPtr(rdPtr);
      end
      if (push) begin
        slots[wrPtr] <= pushData;
        wrPtr <= nextPtr(wrPtr);
      end
      if (push && !pop) level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  assign headData = slots[rdPtr];
  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);

  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  a_r5_level_up: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> level == LVL_W'($past(level) + 1'b1));
  a_r2_level_down: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push) |=> level == LVL_W'($past(level) - 1'b1));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import ipc_mailbox_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int CHAN_COUNT = 12,
  localparam int CHAN_W    = (CHAN_COUNT > 1) ? $clog2(CHAN_COUNT) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mbox_strobe_t                 strobes,
  input  logic [CHAN_W-1:0]            scanSel,
  input  logic [CHAN_COUNT*DATA_W-1:0] chanRespData,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            inHead,
  output logic [DATA_W-1:0]            inStatus,
  output logic [DATA_W-1:0]            outStatus,
  output logic                         inFull,
  output logic                         inEmpty,
  output logic                         outFull
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] inPushData, inHeadRaw, outHeadRaw;
  logic [LVL_W-1:0]  inLevel, outLevel;
  logic              outEmpty;

  always_comb begin
    inPushData = '0;
    for (int i = 0; i < CHAN_COUNT; i++)
      if (scanSel == CHAN_W'(i)) inPushData = chanRespData[i*DATA_W +: DATA_W];
  end

  mbox_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W), .FILL(EMPTY_WORD)) i_inFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.inPush), .pushData(inPushData), .pop(strobes.inPop),
    .headData(inHeadRaw), .level(inLevel), .full(inFull), .empty(inEmpty)
  );

  mbox_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W), .FILL(EMPTY_WORD)) i_outFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.outPush), .pushData(busWdata), .pop(1'b0),
    .headData(outHeadRaw), .level(outLevel), .full(outFull), .empty(outEmpty)
  );

  assign inHead    = inEmpty ? EMPTY_WORD : inHeadRaw;
  assign inStatus  = {inFull, inEmpty, 22'b0, 8'(inLevel)};
  assign outStatus = {outFull, outEmpty, 22'b0, 8'(outLevel)};

  a_r4_empty_head: assert property (@(posedge clk) disable iff (!rstN)
    inEmpty |-> inHeadRaw == EMPTY_WORD);
  a_r5_out_nohead: assert property (@(posedge clk) disable iff (!rstN)
    outEmpty |-> outHeadRaw == EMPTY_WORD);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import ipc_mailbox_pkg::*;
#(
  parameter int CHAN_COUNT   = 12,
  parameter int ADDR_W       = 10,
  parameter int CHAN_FIELD_W = 4,
  localparam int CHAN_W      = (CHAN_COUNT > 1) ? $clog2(CHAN_COUNT) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  busErr,
  output logic                  irqData,
  input  logic [CHAN_COUNT-1:0] chanAvail,
  input  logic [CHAN_COUNT-1:0] chanBusy,
  output logic [CHAN_COUNT-1:0] chanRespAck,
  output logic [CHAN_COUNT-1:0] chanWrValid,
  output logic [DATA_W-1:0]     chanWrData,
  input  logic [DATA_W-1:0]     inHead,
  input  logic [DATA_W-1:0]     inStatus,
  input  logic [DATA_W-1:0]     outStatus,
  input  logic                  inFull,
  input  logic                  inEmpty,
  input  logic                  outFull,
  output mbox_strobe_t          strobes,
  output logic [CHAN_W-1:0]     scanSel
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'(15);

  logic dataIrqEn, errOverflow, errUnderflow;
  logic scanHit, rdAcc, wrAcc, aligned;
  logic isRdWin, isPeek, isSender, isInStat, isCfg, isOutStat, isWrWin;
  logic readHit, writeHit, wrWinAcc, inRange, tgtBusy, deliver;
  logic [CHAN_FIELD_W-1:0] chanField;
  logic [CHAN_COUNT-1:0]   tgtOneHot;
  logic [DATA_W-1:0]       cfgWord;

  // Lowest-numbered ready channel wins: scan from the top down.
  always_comb begin
    scanHit = 1'b0;
    scanSel = '0;
    for (int i = CHAN_COUNT-1; i >= 0; i--)
      if (chanAvail[i]) begin
        scanHit = 1'b1;
        scanSel = CHAN_W'(i);
      end
  end

  always_comb begin
    chanRespAck = '0;
    if (scanHit && !inFull)
      for (int i = 0; i < CHAN_COUNT; i++)
        if (scanSel == CHAN_W'(i)) chanRespAck[i] = 1'b1;
  end

  // Address decode
  assign aligned   = (busAddr[1:0] == 2'b00);
  assign isRdWin   = aligned && ((busAddr & WIN_MASK) == ADDR_W'('h80));
  assign isWrWin   = aligned && ((busAddr & WIN_MASK) == ADDR_W'('hA0));
  assign isPeek    = (busAddr == ADDR_W'('h90));
  assign isSender  = (busAddr == ADDR_W'('h94));
  assign isInStat  = (busAddr == ADDR_W'('h98));
  assign isCfg     = (busAddr == ADDR_W'('h9C));
  assign isOutStat = (busAddr == ADDR_W'('hB8));
  assign rdAcc     = busValid && !busWrite;
  assign wrAcc     = busValid && busWrite;
  assign readHit   = isRdWin || isPeek || isSender || isInStat || isCfg || isOutStat;
  assign writeHit  = isWrWin || isCfg;
  assign busErr    = busValid && (busWrite ? !writeHit : !readHit);

  assign cfgWord = {21'b0, errUnderflow, errOverflow, 1'b0, 3'b0, !inEmpty, 3'b0, dataIrqEn};

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      if (isRdWin || isPeek) busRdata = inHead;
      else if (isInStat)     busRdata = inStatus;
      else if (isCfg)        busRdata = cfgWord;
      else if (isOutStat)    busRdata = outStatus;
    end
  end

  // Request routing
  assign chanField = busWdata[CHAN_FIELD_W-1:0];
  assign inRange   = (32'(chanField) < CHAN_COUNT);
  assign wrWinAcc  = wrAcc && isWrWin;

  always_comb begin
    tgtOneHot = '0;
    tgtBusy   = 1'b0;
    for (int i = 0; i < CHAN_COUNT; i++)
      if (chanField == CHAN_FIELD_W'(i)) begin
        tgtOneHot[i] = 1'b1;
        tgtBusy      = chanBusy[i];
      end
  end

  assign deliver     = wrWinAcc && !outFull && inRange && !tgtBusy;
  assign chanWrValid = deliver ? tgtOneHot : '0;
  assign chanWrData  = busWdata;

  assign strobes.inPush  = scanHit && !inFull;
  assign strobes.inPop   = rdAcc && isRdWin && !inEmpty;
  assign strobes.outPush = wrWinAcc && !outFull && inRange && tgtBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataIrqEn    <= 1'b0;
      errOverflow  <= 1'b0;
      errUnderflow <= 1'b0;
    end else if (wrAcc && isCfg) begin
      dataIrqEn    <= busWdata[0];
      errOverflow  <= 1'b0;
      errUnderflow <= 1'b0;
    end else begin
      if (wrWinAcc && outFull)           errOverflow  <= 1'b1;
      if (rdAcc && isRdWin && inEmpty)   errUnderflow <= 1'b1;
    end
  end

  assign irqData = dataIrqEn && !inEmpty;

  a_r6_one_ack: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanRespAck));
  a_r6_ack_ready: assert property (@(posedge clk) disable iff (!rstN)
    (chanRespAck != '0) |-> ((chanRespAck & chanAvail) == chanRespAck));
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanWrValid));
  a_r7_deliver_or_queue: assert property (@(posedge clk) disable iff (!rstN)
    (chanWrValid != '0) |-> !strobes.outPush);
  a_r7_idle_target: assert property (@(posedge clk) disable iff (!rstN)
    (chanWrValid != '0) |-> ((chanWrValid & chanBusy) == '0));
  a_r3_empty_sentinel: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && isRdWin && inEmpty) |-> busRdata == EMPTY_WORD);
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0 && chanWrValid == '0 && !strobes.outPush && !strobes.inPop));
  a_r10_irq_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqData |-> !inEmpty);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int CHAN_COUNT   = 12,
  parameter int ADDR_W       = 10,
  parameter int CHAN_FIELD_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         busValid,
  input  logic                         busWrite,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  output logic                         busErr,
  output logic                         irqData,
  input  logic [CHAN_COUNT-1:0]        chanAvail,
  input  logic [CHAN_COUNT*DATA_W-1:0] chanRespData,
  output logic [CHAN_COUNT-1:0]        chanRespAck,
  input  logic [CHAN_COUNT-1:0]        chanBusy,
  output logic [CHAN_COUNT-1:0]        chanWrValid,
  output logic [DATA_W-1:0]            chanWrData
);
  localparam int CHAN_W = (CHAN_COUNT > 1) ? $clog2(CHAN_COUNT) : 1;

  mbox_strobe_t      strobes;
  logic [CHAN_W-1:0] scanSel;
  logic [DATA_W-1:0] inHead, inStatus, outStatus;
  logic              inFull, inEmpty, outFull;

  mbox_ctrl #(.CHAN_COUNT(CHAN_COUNT), .ADDR_W(ADDR_W), .CHAN_FIELD_W(CHAN_FIELD_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .irqData(irqData),
    .chanAvail(chanAvail), .chanBusy(chanBusy), .chanRespAck(chanRespAck),
    .chanWrValid(chanWrValid), .chanWrData(chanWrData),
    .inHead(inHead), .inStatus(inStatus), .outStatus(outStatus),
    .inFull(inFull), .inEmpty(inEmpty), .outFull(outFull),
    .strobes(strobes), .scanSel(scanSel)
  );

  mbox_datapath #(.DEPTH(DEPTH), .CHAN_COUNT(CHAN_COUNT)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scanSel(scanSel),
    .chanRespData(chanRespData), .busWdata(busWdata),
    .inHead(inHead), .inStatus(inStatus), .outStatus(outStatus),
    .inFull(inFull), .inEmpty(inEmpty), .outFull(outFull)
  );
endmodule

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NCH = 12;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busErr, irqData;
  logic [NCH-1:0] chanAvail = '0, chanBusy = '0;
  logic [NCH*32-1:0] chanRespData;
  logic [NCH-1:0] chanRespAck, chanWrValid;
  logic [31:0] chanWrData;

  int checks = 0, errors = 0;
  logic [31:0] inQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox #(.DEPTH(DEPTH), .CHAN_COUNT(NCH), .ADDR_W(AW)) i_ipc_mailbox (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .irqData(irqData), .chanAvail(chanAvail), .chanRespData(chanRespData),
    .chanRespAck(chanRespAck), .chanBusy(chanBusy), .chanWrValid(chanWrValid),
    .chanWrData(chanWrData)
  );

  function automatic logic [31:0] respWord(input int ch);
    return 32'hC0DE_0000 + 32'(ch);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1; d = busRdata; e = busErr;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [31:0] v,
                         output logic [NCH-1:0] wv, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = v;
    #1; wv = chanWrValid; e = busErr;
    chk("R7 write data port", chanWrData, v);
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readExpect(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    doRead(a, d, e);
    chk(req, d, exp);
  endtask

  // Scanner: expect the lowest ready channel to be taken while the model has room.
  task automatic runScan(input int n);
    for (int c = 0; c < n; c++) begin
      logic [NCH-1:0] expAck;
      int taken;
      @(negedge clk);
      expAck = '0; taken = -1;
      if (inQ.size() < DEPTH)
        for (int i = NCH-1; i >= 0; i--) if (chanAvail[i]) taken = i;
      if (taken >= 0) expAck[taken] = 1'b1;
      chk("R6 scan acknowledge", 32'(chanRespAck), 32'(expAck));
      @(posedge clk); #1;
      if (taken >= 0) begin
        inQ.push_back(respWord(taken));
        chanAvail[taken] = 1'b0;
      end
    end
  endtask

  task automatic testReset();
    readExpect("R1 inbound status", AW'('h98), 32'h4000_0000);
    readExpect("R1 outbound status", AW'('hB8), 32'h4000_0000);
    readExpect("R1 peek empty", AW'('h90), 32'hFFFF_FFFF);
    readExpect("R1 config", AW'('h9C), 32'h0);
    chk("R1 irq low", 32'(irqData), 32'h0);
  endtask

  task automatic testPriorityAndIrq();
    logic [NCH-1:0] wv; logic e;
    chanAvail = NCH'((1 << 9) | (1 << 2) | (1 << 5));
    runScan(4);
    readExpect("R5 inbound level 3", AW'('h98), 32'h0000_0003);
    readExpect("R10 pending without enable", AW'('h9C), 32'h0000_0010);
    chk("R10 irq off when disabled", 32'(irqData), 32'h0);
    doWrite(AW'('h9C), 32'hFFFF_FFF1, wv, e);
    @(negedge clk);
    chk("R10 irq on", 32'(irqData), 32'h1);
    readExpect("R10 config only bit0 taken", AW'('h9C), 32'h0000_0011);
    readExpect("R2 pop at 0x80", AW'('h80), inQ.pop_front());
    readExpect("R2 pop at 0x84", AW'('h84), inQ.pop_front());
    readExpect("R2 pop at 0x8C", AW'('h8C), inQ.pop_front());
    @(negedge clk);
    chk("R10 irq drops when empty", 32'(irqData), 32'h0);
    readExpect("R5 inbound empty again", AW'('h98), 32'h4000_0000);
  endtask

  task automatic testUnderflow();
    logic [NCH-1:0] wv; logic e;
    readExpect("R3 empty read sentinel", AW'('h88), 32'hFFFF_FFFF);
    readExpect("R3 underflow flag", AW'('h9C), 32'h0000_0401);
    readExpect("R3 nothing popped", AW'('h98), 32'h4000_0000);
    doWrite(AW'('h9C), 32'h0, wv, e);
    readExpect("R10 config write clears errors", AW'('h9C), 32'h0);
  endtask

  task automatic testFill();
    chanAvail = '1;
    runScan(10);
    readExpect("R5 inbound full", AW'('h98), 32'h8000_0008);
    readExpect("R4 peek head", AW'('h90), respWord(0));
    readExpect("R4 peek keeps level", AW'('h98), 32'h8000_0008);
    readExpect("R2 pop while full", AW'('h80), inQ.pop_front());
    runScan(2);
    chk("R6 later channels still waiting", 32'(chanAvail), 32'(NCH'('hE00)));
    chanAvail = '0;
    for (int k = 0; k < DEPTH; k++)
      readExpect("R2 drain order", AW'('h84), inQ.pop_front());
  endtask

  task automatic testOutbound();
    logic [NCH-1:0] wv; logic e;
    chanBusy = '0;
    doWrite(AW'('hA0), 32'h1234_5003, wv, e);
    chk("R7 direct delivery", 32'(wv), 32'h0000_0008);
    readExpect("R7 direct skips queue", AW'('hB8), 32'h4000_0000);
    chanBusy = NCH'(1 << 6);
    doWrite(AW'('hA4), 32'h0000_0106, wv, e);
    chk("R7 busy not delivered", 32'(wv), 32'h0);
    readExpect("R7 busy queued", AW'('hB8), 32'h0000_0001);
    doWrite(AW'('hA8), 32'h0000_000D, wv, e);
    chk("R8 out of range not delivered", 32'(wv), 32'h0);
    readExpect("R8 out of range not queued", AW'('hB8), 32'h0000_0001);
    for (int k = 0; k < DEPTH-1; k++) doWrite(AW'('hAC), 32'h0000_0206, wv, e);
    readExpect("R5 outbound full", AW'('hB8), 32'h8000_0008);
    doWrite(AW'('hA0), 32'h0000_0003, wv, e);
    chk("R9 full drops idle target", 32'(wv), 32'h0);
    readExpect("R9 overflow flag", AW'('h9C), 32'h0000_0200);
    doWrite(AW'('h9C), 32'h0, wv, e);
    readExpect("R9 overflow cleared", AW'('h9C), 32'h0);
    chanBusy = '0;
  endtask

  task automatic testUndefined();
    logic [31:0] d; logic e; logic [NCH-1:0] wv;
    doRead(AW'('h200), d, e);
    chk("R11 undefined read zero", d, 32'h0);
    chk("R11 undefined read strobe", 32'(e), 32'h1);
    doRead(AW'('hA0), d, e);
    chk("R11 read of write window strobe", 32'(e), 32'h1);
    doWrite(AW'('h98), 32'h1, wv, e);
    chk("R11 write to status strobe", 32'(e), 32'h1);
    readExpect("R11 write ignored", AW'('h9C), 32'h0);
    doRead(AW'('h98), d, e);
    chk("R11 defined read no strobe", 32'(e), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) chanRespData[i*32 +: 32] = respWord(i);
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testPriorityAndIrq();
    testUnderflow();
    testFill();
    testOutbound();
    testUndefined();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule